// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the synchronous write path of a NOR-style flash memory controller. It watches each host write, which carries an address and a data byte, and follows the multi-write unlock sequences that guard every command. When a sequence completes, it issues a one-cycle request that names the operation and, where the operation needs one, the sector. Any write that does not fit the expected step is dropped without comment, and the decoder goes back to waiting for a fresh unlock.

The decoder also holds the current read mode: array, silicon ID or status. While the ID mode is active it drives the identification codes on a separate output. It captures the byte/word width select on the third write of each command, and the rest of the controller reads the captured value from an output. Array storage, erase and program timing, and pin-level bus timing belong to other blocks.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While reset is held and after it is released, no request is issued, `read_mode` is 0 (array), `wide_q` is 0 and `id_data` is 0.
- R2: A command starts with data AAH at an address whose low 16 bits are 5555H, followed by data 55H at an address whose low 16 bits are 2AAAH. Address bits above bit 15 are ignored in these unlock writes.
- R3: The third write must go to low address 5555H. Its data selects one of these `req_op` codes: F0H gives 1 (read array), 90H gives 2 (silicon ID), A0H gives 3 (page program), B0H gives 6 (erase suspend), D0H gives 7 (erase resume), 70H gives 8 (status read), 50H gives 9 (status clear) and E0H gives 12 (abort). Any other byte gives no request, except 80H and 60H (see R4 and R5).
- R4: A third byte of 80H requires a further AAH@5555H and 55H@2AAAH pair. The next write then gives code 4 (chip erase) for data 10H at low address 5555H, or code 5 (sector erase) for data 30H at any address. No other write gives a request.
- R5: A third byte of 60H requires a further unlock pair. The next write then gives code 10 (sector protect) for data 20H or code 11 (sector unprotect) for data 40H, at any address.
- R6: For codes 5, 10 and 11, `req_sector` holds the top SECT_W address bits of the final write. For all other codes it is 0.
- R7: A write whose address or data does not match its step gives no request and returns the decoder to the first step. The next complete sequence is then decoded normally.
- R8: `req_valid` is high for exactly the one cycle after the clock edge that captures the final write.
- R9: Codes 1, 9 and 12 set `read_mode` to 0 (array). Code 2 sets it to 1 (ID). Every other code sets it to 2 (status). The new mode is visible in the same cycle as the request.
- R10: In ID mode, `id_data` is 00C2H when `id_sel` is 0 and 00F9H when `id_sel` is 1. In any other mode it is 0.
- R11: `wide_q` takes the value of `word_mode` on every write that arrives at the third step, whatever its data. It holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| word_mode | input | 1 | Width select, 1 = 16-bit |
| id_sel | input | 1 | ID code select, 0 = manufacturer, 1 = device |
| req_valid | output | 1 | One-cycle operation request |
| req_op | output | 4 | Operation code of the request |
| req_sector | output | SECT_W | Sector of the request |
| wide_q | output | 1 | Width captured on the last third-step write |
| read_mode | output | 2 | 0 array, 1 ID, 2 status |
| id_data | output | 16 | Identification code in ID mode |

## Verification
A corrupted sequence step can show up in two ways at the ports. A request may appear on a write that should have been dropped, or a request may be missing, or carry the wrong code, on the write after a mismatch. Either shows one cycle after the final write. A wrong read mode shows on `read_mode` and `id_data` in that same cycle. The sweeps try every data byte at the third step and at both final steps, so a one-bit decode error in any branch produces a wrong or missing request.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W = 21,
  parameter int SECT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              word_mode,
  input  logic              id_sel,
  output logic              req_valid,
  output logic [3:0]        req_op,
  output logic [SECT_W-1:0] req_sector,
  output logic              wide_q,
  output logic [1:0]        read_mode,
  output logic [15:0]       id_data
);

  localparam logic [3:0] OP_NONE = 4'd0,  OP_RA   = 4'd1,  OP_ID  = 4'd2,
                         OP_PROG = 4'd3,  OP_CHIP = 4'd4,  OP_SECT = 4'd5,
                         OP_SUSP = 4'd6,  OP_RES  = 4'd7,  OP_SR  = 4'd8,
                         OP_CLR  = 4'd9,  OP_PROT = 4'd10, OP_UNP = 4'd11,
                         OP_ABT  = 4'd12;
  localparam logic [1:0] M_ARR = 2'd0, M_ID = 2'd1, M_STAT = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_U1, S_CMD, S_EU1, S_EU2, S_EFIN, S_PU1, S_PU2, S_PFIN
  } step_t;

  step_t st, st_n;
  logic [3:0] op_n;
  logic [SECT_W-1:0] sect_n;

  wire hit5 = wr_addr[15:0] == 16'h5555;
  wire hit2 = wr_addr[15:0] == 16'h2AAA;
  wire [SECT_W-1:0] sect_a = wr_addr[ADDR_W-1 -: SECT_W];

  always_comb begin
    st_n   = st;
    op_n   = OP_NONE;
    sect_n = '0;
    if (wr_en) begin
      st_n = S_IDLE;
      case (st)
        S_IDLE: if (hit5 && wr_data == 8'hAA) st_n = S_U1;
        S_U1:   if (hit2 && wr_data == 8'h55) st_n = S_CMD;
        S_CMD:
          if (hit5) begin
            case (wr_data)
              8'hF0: op_n = OP_RA;
              8'h90: op_n = OP_ID;
              8'hA0: op_n = OP_PROG;
              8'hB0: op_n = OP_SUSP;
              8'hD0: op_n = OP_RES;
              8'h70: op_n = OP_SR;
              8'h50: op_n = OP_CLR;
              8'hE0: op_n = OP_ABT;
              8'h80: st_n = S_EU1;
              8'h60: st_n = S_PU1;
              default: ;
            endcase
          end
        S_EU1:  if (hit5 && wr_data == 8'hAA) st_n = S_EU2;
        S_EU2:  if (hit2 && wr_data == 8'h55) st_n = S_EFIN;
        S_EFIN:
          if (wr_data == 8'h30) begin
            op_n   = OP_SECT;
            sect_n = sect_a;
          end else if (hit5 && wr_data == 8'h10) begin
            op_n = OP_CHIP;
          end
        S_PU1:  if (hit5 && wr_data == 8'hAA) st_n = S_PU2;
        S_PU2:  if (hit2 && wr_data == 8'h55) st_n = S_PFIN;
        S_PFIN:
          if (wr_data == 8'h20 || wr_data == 8'h40) begin
            op_n   = (wr_data == 8'h20) ? OP_PROT : OP_UNP;
            sect_n = sect_a;
          end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      req_valid  <= 1'b0;
      req_op     <= OP_NONE;
      req_sector <= '0;
      wide_q     <= 1'b0;
      read_mode  <= M_ARR;
    end else begin
      st         <= st_n;
      req_valid  <= op_n != OP_NONE;
      req_op     <= op_n;
      req_sector <= sect_n;
      if (wr_en && st == S_CMD) wide_q <= word_mode;
      if (op_n != OP_NONE)
        read_mode <= (op_n == OP_RA || op_n == OP_CLR || op_n == OP_ABT) ? M_ARR :
                     (op_n == OP_ID) ? M_ID : M_STAT;
    end
  end

  assign id_data = (read_mode == M_ID) ? {8'h00, id_sel ? 8'hF9 : 8'hC2} : 16'h0000;

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);
  // R8
  req_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(wr_en));
  // R3
  op_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_op != OP_NONE && req_op <= OP_ABT));
  // R9
  prog_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_PROG) |-> read_mode == M_STAT);
  // R11
  wide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wide_q));
  // R6
  sector_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op == OP_CHIP || req_op == OP_PROG)) |-> req_sector == '0);

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
  localparam int AW = 21, SW = 5;
  logic clk = 0, rst_n = 0, wr_en = 0, word_mode = 0, id_sel = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic req_valid, wide_q;
  logic [3:0] req_op;
  logic [SW-1:0] req_sector;
  logic [1:0] read_mode;
  logic [15:0] id_data;
  int checks = 0, errors = 0;
  logic [1:0] mode_m = 2'd0;
  bit done = 0;

  always #10 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .SECT_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .word_mode(word_mode), .id_sel(id_sel), .req_valid(req_valid), .req_op(req_op),
    .req_sector(req_sector), .wide_q(wide_q), .read_mode(read_mode), .id_data(id_data));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic logic [3:0] cmd_op(input logic [7:0] d);
    case (d)
      8'hF0: return 4'd1;  8'h90: return 4'd2;  8'hA0: return 4'd3;
      8'hB0: return 4'd6;  8'hD0: return 4'd7;  8'h70: return 4'd8;
      8'h50: return 4'd9;  8'hE0: return 4'd12; default: return 4'd0;
    endcase
  endfunction

  function automatic logic [1:0] mode_of(input logic [3:0] op);
    if (op == 4'd1 || op == 4'd9 || op == 4'd12) return 2'd0;
    if (op == 4'd2) return 2'd1;
    return 2'd2;
  endfunction

  task automatic expect_req(input logic [3:0] op, input logic [SW-1:0] sec, input string tag);
    if (op == 4'd0) begin
      chk(req_valid == 0, tag, int'(req_valid), 0);
    end else begin
      mode_m = mode_of(op);
      chk(req_valid == 1 && req_op == op, tag, int'(req_op), int'(op));
      chk(req_sector == sec, {tag, " R6 sector"}, int'(req_sector), int'(sec));
      chk(read_mode == mode_m, {tag, " R9 mode"}, int'(read_mode), int'(mode_m));
    end
  endtask

  task automatic unlock(input logic [SW-1:0] hi);
    wr({hi, 16'h5555}, 8'hAA);
    wr({~hi, 16'h2AAA}, 8'h55);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    chk(req_valid == 0 && read_mode == 0 && wide_q == 0 && id_data == 0, "R1 in reset",
        int'(read_mode), 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_valid == 0 && read_mode == 0 && wide_q == 0 && id_data == 0, "R1 after reset",
        int'({req_valid, wide_q, read_mode}), 0);

    // R2 R3: sweep third-step byte, varying upper address bits
    for (int d = 0; d < 256; d++) begin
      logic [3:0] e;
      e = cmd_op(8'(d));
      unlock(5'(d));
      wr({5'(d * 7), 16'h5555}, 8'(d));
      expect_req(e, '0, $sformatf("R3 cmd %0h", d));
      if (d == 8'h80 || d == 8'h60) begin
        wr('0, 8'h00);
        expect_req(4'd0, '0, "R7 junk after setup");
      end
      chk(read_mode == mode_m, "R9 mode hold", int'(read_mode), int'(mode_m));
    end

    // R3: right data at the wrong third address gives nothing
    unlock(5'd0);
    wr({5'd0, 16'h5554}, 8'hF0);
    expect_req(4'd0, '0, "R3 wrong cmd addr");

    // R4: erase final-step sweep
    for (int d = 0; d < 256; d++) begin
      logic [SW-1:0] s;
      logic [15:0] lo;
      logic [3:0] e;
      s  = 5'(d + 3);
      lo = d[0] ? 16'h1234 : 16'h5555;
      e  = (d == 8'h30) ? 4'd5 : (d == 8'h10 && lo == 16'h5555) ? 4'd4 : 4'd0;
      unlock(s);
      wr({s, 16'h5555}, 8'h80);
      unlock(~s);
      wr({s, lo}, 8'(d));
      expect_req(e, (e == 4'd5) ? s : '0, $sformatf("R4 erase %0h", d));
    end
    unlock(5'd1); wr({5'd1, 16'h5555}, 8'h80); unlock(5'd1);
    wr({5'd9, 16'h1234}, 8'h10);
    expect_req(4'd0, '0, "R4 chip erase wrong addr");

    // R5: protect final-step sweep
    for (int d = 0; d < 256; d++) begin
      logic [SW-1:0] s;
      logic [3:0] e;
      s = 5'(d * 5);
      e = (d == 8'h20) ? 4'd10 : (d == 8'h40) ? 4'd11 : 4'd0;
      unlock(s);
      wr({s, 16'h5555}, 8'h60);
      unlock(s);
      wr({s, 16'h0000}, 8'(d));
      expect_req(e, s, $sformatf("R5 prot %0h", d));
    end

    // R7: corrupt each of the five writes of an erase sequence
    for (int k = 0; k < 5; k++) begin
      wr({5'd0, 16'h5555}, (k == 0) ? 8'hAB : 8'hAA);
      expect_req(4'd0, '0, "R7 step");
      wr({5'd0, (k == 1) ? 16'h2AAB : 16'h2AAA}, 8'h55);
      expect_req(4'd0, '0, "R7 step");
      wr({5'd0, 16'h5555}, (k == 2) ? 8'h81 : 8'h80);
      expect_req(4'd0, '0, "R7 step");
      wr({5'd0, 16'h5555}, (k == 3) ? 8'hA5 : 8'hAA);
      expect_req(4'd0, '0, "R7 step");
      wr({5'd0, 16'h2AAA}, (k == 4) ? 8'h54 : 8'h55);
      expect_req(4'd0, '0, "R7 step");
      wr({5'd4, 16'h0000}, 8'h30);
      expect_req(4'd0, '0, $sformatf("R7 corrupt step %0d", k));
      unlock(5'd0); wr({5'd0, 16'h5555}, 8'h70);
      expect_req(4'd8, '0, "R7 recovery");
    end

    // R8: request lasts one cycle
    unlock(5'd0); wr({5'd0, 16'h5555}, 8'hA0);
    expect_req(4'd3, '0, "R8 program");
    @(negedge clk);
    chk(req_valid == 0, "R8 single cycle", int'(req_valid), 0);

    // R10 R11: ID codes and width capture
    for (int w = 0; w < 2; w++) begin
      word_mode = 1'(~w);
      unlock(5'd2);
      @(negedge clk); word_mode = 1'(w);
      wr({5'd2, 16'h5555}, 8'h90);
      word_mode = 1'(~w);
      expect_req(4'd2, '0, "R10 id entry");
      chk(wide_q == 1'(w), "R11 width capture", int'(wide_q), w);
      id_sel = 0; #1;
      chk(id_data == 16'h00C2, "R10 manufacturer", int'(id_data), 16'h00C2);
      id_sel = 1; #1;
      chk(id_data == 16'h00F9, "R10 device", int'(id_data), 16'h00F9);
      wr({5'd2, 16'h5555}, 8'hAA);
      chk(wide_q == 1'(w), "R11 hold", int'(wide_q), w);
      wr({5'd2, 16'h2AAA}, 8'h55);
      wr({5'd2, 16'h0001}, 8'h12);
      expect_req(4'd0, '0, "R3 bad third addr");
      chk(wide_q == 1'(~w), "R11 any third write", int'(wide_q), 1 - w);
    end
    unlock(5'd0); wr({5'd0, 16'h5555}, 8'hF0);
    expect_req(4'd1, '0, "R9 back to array");
    chk(id_data == 16'h0000, "R10 zero outside ID", int'(id_data), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule